// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block picks which page frame to evict when a new page must be brought into a fixed pool of frames. For every frame it holds a use bit, a dirty bit and a small sweep counter, and it keeps one circular hand that points at the next frame to inspect. References to a frame set its use bit, and write references also set its dirty bit. Nothing moves the hand except a replacement request.

When a request is accepted, the hand inspects one frame per clock cycle. A frame that was used recently loses its use bit and has its counter reset, and the hand moves on. A frame that was not used has its counter incremented. It becomes the victim once the counter reaches its threshold: one visit for a clean frame, two visits for a dirty frame. On the first unused visit to a dirty frame, the block raises a write-back request on a separate channel, so that the page is often clean by the time it is evicted.

The victim index and its dirty flag are returned on a response handshake. Accepting the response marks the frame as holding a fresh page, which clears its use bit, dirty bit and counter. A done pulse from the backing store clears the dirty bit of a frame whose write-back has finished.

Top module: `clock_victim_sel`

## Requirements
- R1: A cycle with `refValid` high sets the use bit of frame `refFrame`. If `refWrite` is also high, it sets that frame's dirty bit too.
- R2: The hand moves only while a request is being served. It advances by exactly one frame per cycle and wraps from the last frame to frame 0. After reset it points at frame 0.
- R3: When the hand inspects a frame whose use bit is set, it clears the use bit and the counter, and that frame is not chosen in that inspection.
- R4: A clean frame with its use bit clear is chosen on its first inspection.
- R5: A dirty frame with its use bit clear is chosen on its second consecutive unused inspection, and `rspDirty` is then 1. On its first unused inspection, `wbValid` rises with `wbFrame` set to that frame, provided the write-back channel is free.
- R6: The response appears exactly one cycle per inspected frame after the request is accepted. When every frame has its use bit set, the frame at the starting hand position is chosen, after at most three full turns of the hand.
- R7: `reqReady` is high only when no request is in progress. `rspValid`, `rspFrame` and `rspDirty` hold steady until `rspReady` is seen. After the hand chooses a frame, it points at the following frame.
- R8: A `wbDoneValid` pulse clears the dirty bit of frame `wbDoneFrame`. A later unused inspection of that frame then treats it as clean.
- R9: The cycle that accepts a response clears the chosen frame's use bit, dirty bit and counter.
- R10: If a reference targets the frame under the hand in the same cycle that frame is inspected, the reference wins. The frame is not chosen, its counter is cleared, and its use bit stays set.
- R11: `wbValid` and `wbFrame` hold until `wbReady` is high. While the channel is held, a dirty frame that reaches its first unused inspection raises no new request and stays dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A frame is referenced this cycle |
| refFrame | input | 3 | Index of the referenced frame |
| refWrite | input | 1 | The reference modifies the frame |
| reqValid | input | 1 | Replacement request |
| reqReady | output | 1 | Selector is idle and accepts a request |
| rspValid | output | 1 | Victim result is available |
| rspReady | input | 1 | Consumer takes the victim result |
| rspFrame | output | 3 | Index of the chosen victim |
| rspDirty | output | 1 | Victim must be written back before reuse |
| wbValid | output | 1 | Early write-back request |
| wbReady | input | 1 | Backing store accepts the write-back request |
| wbFrame | output | 3 | Frame to write back |
| wbDoneValid | input | 1 | A write-back has completed |
| wbDoneFrame | input | 3 | Frame whose write-back completed |

## Verification
The hardest situation to create from the ports is a reference that lands on the very frame under the hand during the cycle it is inspected. The hand position is never visible, and the window is a single cycle. The bench reaches this case by reasoning: it keeps its own copy of the hand, issues a request, and drives a reference to the predicted frame in the cycle right after acceptance. A second hard case is a stalled write-back channel during a long sweep in which every frame is dirty and recently used. The bench holds `wbReady` low through a full three-turn sweep and checks that only the first request is raised.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;

  // strobes from the sweep control to the frame datapath
  typedef struct packed {
    logic step;     // inspect the frame under the hand and advance
    logic select;   // the inspected frame becomes the victim
    logic rspFire;  // victim handed over, install fresh page
    logic wbIssue;  // load the early write-back register
  } sweepStrobes_t;

  // what the datapath reports about the frame under the hand
  typedef struct packed {
    logic pickHere;
    logic wbHere;
    logic wbFree;
  } sweepStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_RESP
  } sweepState_t;

endpackage

// File: rtl/clock_victim_ctrl.sv
module clock_victim_ctrl
  import clock_victim_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          rspReady,
  input  sweepStatus_t  status,
  output sweepStrobes_t strb,
  output logic          reqReady,
  output logic          rspValid
);

  sweepState_t stateQ, stateD;

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) stateD = ST_SWEEP;
      end
      ST_SWEEP: begin
        strb.step    = 1'b1;
        strb.select  = status.pickHere;
        strb.wbIssue = status.wbHere && status.wbFree;
        if (status.pickHere) stateD = ST_RESP;
      end
      ST_RESP: begin
        strb.rspFire = rspReady;
        if (rspReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspValid = (stateQ == ST_RESP);

  // R7: an offered victim stays offered until taken
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R7: a new request is taken only once the previous victim is gone
  p_idle_after_take_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> reqReady && !rspValid);

endmodule

// File: rtl/clock_victim_datapath.sv
module clock_victim_datapath
  import clock_victim_pkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int CLEAN_N = 1,
  parameter int DIRTY_N = 2,
  parameter int WB_AT   = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        refValid,
  input  logic [$clog2(FRAMES)-1:0]   refFrame,
  input  logic                        refWrite,
  input  logic                        wbReady,
  input  logic                        wbDoneValid,
  input  logic [$clog2(FRAMES)-1:0]   wbDoneFrame,
  input  sweepStrobes_t               strb,
  output sweepStatus_t                status,
  output logic [$clog2(FRAMES)-1:0]   victimFrame,
  output logic                        victimDirty,
  output logic                        wbValid,
  output logic [$clog2(FRAMES)-1:0]   wbFrame
);

  localparam int IDX_W = $clog2(FRAMES);
  localparam int CNT_W = $clog2(DIRTY_N + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  logic [FRAMES-1:0] useQ;
  logic [FRAMES-1:0] dirtyQ;
  logic [CNT_W-1:0]  cntQ [FRAMES];
  logic [IDX_W-1:0]  handQ;
  logic [IDX_W-1:0]  victimQ;
  logic              victimDirtyQ;
  logic              wbValidQ;
  logic [IDX_W-1:0]  wbFrameQ;

  logic             refAtHand;
  logic             effUse;
  logic [CNT_W-1:0] nextCnt;
  logic             reached;

  // evaluation of the frame under the hand
  always_comb begin
    refAtHand = refValid && (refFrame == handQ);
    effUse    = useQ[handQ] || refAtHand;
    nextCnt   = cntQ[handQ] + CNT_W'(1);
    reached   = dirtyQ[handQ] ? (nextCnt >= CNT_W'(DIRTY_N))
                              : (nextCnt >= CNT_W'(CLEAN_N));
    status.pickHere = !effUse && reached;
    status.wbHere   = !effUse && !reached && dirtyQ[handQ]
                      && (nextCnt == CNT_W'(WB_AT));
    status.wbFree   = !wbValidQ || wbReady;
  end

  // hand, victim latch and early write-back register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      handQ        <= '0;
      victimQ      <= '0;
      victimDirtyQ <= 1'b0;
      wbValidQ     <= 1'b0;
      wbFrameQ     <= '0;
    end else begin
      if (strb.step) handQ <= (handQ == LAST_IDX) ? '0 : handQ + IDX_W'(1);
      if (strb.select) begin
        victimQ      <= handQ;
        victimDirtyQ <= dirtyQ[handQ];
      end
      if (strb.wbIssue) begin
        wbValidQ <= 1'b1;
        wbFrameQ <= handQ;
      end else if (wbReady) begin
        wbValidQ <= 1'b0;
      end
    end
  end

  // per-frame state
  for (genvar gi = 0; gi < FRAMES; gi++) begin : g_frame
    logic refHit, atHand, installHere, doneHere;
    always_comb begin
      refHit      = refValid && (refFrame == IDX_W'(gi));
      atHand      = strb.step && (handQ == IDX_W'(gi));
      installHere = strb.rspFire && (victimQ == IDX_W'(gi));
      doneHere    = wbDoneValid && (wbDoneFrame == IDX_W'(gi));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        useQ[gi]   <= 1'b0;
        dirtyQ[gi] <= 1'b0;
        cntQ[gi]   <= '0;
      end else begin
        if (refHit)                  useQ[gi] <= 1'b1;
        else if (atHand || installHere) useQ[gi] <= 1'b0;

        if (refHit && refWrite)           dirtyQ[gi] <= 1'b1;
        else if (installHere || doneHere) dirtyQ[gi] <= 1'b0;

        if (atHand) begin
          if (effUse || status.pickHere) cntQ[gi] <= '0;
          else                           cntQ[gi] <= nextCnt;
        end else if (installHere) begin
          cntQ[gi] <= '0;
        end
      end
    end
  end

  assign victimFrame = victimQ;
  assign victimDirty = victimDirtyQ;
  assign wbValid     = wbValidQ;
  assign wbFrame     = wbFrameQ;

  // R2: the hand only moves on a sweep step
  p_hand_still_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(handQ));

  // R11: a pending write-back request is held with its frame
  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbValidQ && !wbReady |=> wbValidQ && $stable(wbFrameQ));

  // R10: a reference colliding with the inspection keeps the use bit
  p_ref_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    refValid && strb.step && (refFrame == handQ) |=> useQ[$past(refFrame)]);

  // R8: write-back completion clears the dirty bit unless rewritten
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbDoneValid && !(refValid && refWrite && (refFrame == wbDoneFrame))
    |=> !dirtyQ[$past(wbDoneFrame)]);

  // R3: an inspected, recently used frame is never picked
  p_used_skipped_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && useQ[handQ] |-> !strb.select);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import clock_victim_pkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int CLEAN_N = 1,
  parameter int DIRTY_N = 2,
  parameter int WB_AT   = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       refValid,
  input  logic [$clog2(FRAMES)-1:0]  refFrame,
  input  logic                       refWrite,
  input  logic                       reqValid,
  output logic                       reqReady,
  output logic                       rspValid,
  input  logic                       rspReady,
  output logic [$clog2(FRAMES)-1:0]  rspFrame,
  output logic                       rspDirty,
  output logic                       wbValid,
  input  logic                       wbReady,
  output logic [$clog2(FRAMES)-1:0]  wbFrame,
  input  logic                       wbDoneValid,
  input  logic [$clog2(FRAMES)-1:0]  wbDoneFrame
);

  sweepStrobes_t strb;
  sweepStatus_t  status;

  clock_victim_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .status   (status),
    .strb     (strb),
    .reqReady (reqReady),
    .rspValid (rspValid)
  );

  clock_victim_datapath #(
    .FRAMES  (FRAMES),
    .CLEAN_N (CLEAN_N),
    .DIRTY_N (DIRTY_N),
    .WB_AT   (WB_AT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .refValid    (refValid),
    .refFrame    (refFrame),
    .refWrite    (refWrite),
    .wbReady     (wbReady),
    .wbDoneValid (wbDoneValid),
    .wbDoneFrame (wbDoneFrame),
    .strb        (strb),
    .status      (status),
    .victimFrame (rspFrame),
    .victimDirty (rspDirty),
    .wbValid     (wbValid),
    .wbFrame     (wbFrame)
  );

  // R7: the offered victim does not change while it waits
  p_rsp_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspFrame) && $stable(rspDirty));

endmodule

// File: tb/tb_clock_victim_sel.sv
module tb_clock_victim_sel;

  localparam int F = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refValid = 1'b0;
  logic [2:0] refFrame = '0;
  logic       refWrite = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       rspValid;
  logic       rspReady = 1'b0;
  logic [2:0] rspFrame;
  logic       rspDirty;
  logic       wbValid;
  logic       wbReady = 1'b1;
  logic [2:0] wbFrame;
  logic       wbDoneValid = 1'b0;
  logic [2:0] wbDoneFrame = '0;

  always #5 clk = ~clk;

  clock_victim_sel dut (
    .clk(clk), .rstN(rstN),
    .refValid(refValid), .refFrame(refFrame), .refWrite(refWrite),
    .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .rspReady(rspReady), .rspFrame(rspFrame), .rspDirty(rspDirty),
    .wbValid(wbValid), .wbReady(wbReady), .wbFrame(wbFrame),
    .wbDoneValid(wbDoneValid), .wbDoneFrame(wbDoneFrame)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // reference model state
  bit mUse [F];
  bit mDirty [F];
  int mCnt [F];
  int mHand;
  int expWb [64];
  int expWbN;
  int wbCap [64];
  int wbCapN = 0;

  always @(negedge clk) begin
    if (wbValid && wbReady && wbCapN < 64) begin
      wbCap[wbCapN] = int'(wbFrame);
      wbCapN++;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  function automatic void modelSweep(input bit stall, output int victim,
                                     output int vd, output int steps);
    bit freeCh = 1;
    steps = 0; expWbN = 0; victim = -1; vd = 0;
    for (int guard = 0; guard < 1000; guard++) begin
      int h = mHand;
      steps++;
      mHand = (h + 1) % F;
      if (mUse[h]) begin
        mUse[h] = 0; mCnt[h] = 0;
      end else begin
        int nc = mCnt[h] + 1;
        int thr = mDirty[h] ? 2 : 1;
        if (nc >= thr) begin
          victim = h; vd = mDirty[h]; mCnt[h] = 0;
          return;
        end
        mCnt[h] = nc;
        if (mDirty[h] && nc == 1 && freeCh) begin
          expWb[expWbN] = h; expWbN++;
          if (stall) freeCh = 0;
        end
      end
    end
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    refValid = 0; reqValid = 0; rspReady = 0; wbDoneValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < F; i++) begin mUse[i] = 0; mDirty[i] = 0; mCnt[i] = 0; end
    mHand = 0;
    @(negedge clk);
  endtask

  task automatic doRef(input int fr, input bit wr);
    refValid = 1; refFrame = 3'(fr); refWrite = wr;
    @(negedge clk);
    refValid = 0; refWrite = 0;
    mUse[fr] = 1;
    if (wr) mDirty[fr] = 1;
  endtask

  task automatic doDone(input int fr);
    wbDoneValid = 1; wbDoneFrame = 3'(fr);
    @(negedge clk);
    wbDoneValid = 0;
    mDirty[fr] = 0;
  endtask

  task automatic doRequest(input bit stall, input int collide, input int delay,
                           input string tag);
    int victim, vd, steps, n;
    if (collide >= 0) mUse[collide] = 1;
    modelSweep(stall, victim, vd, steps);
    if (collide >= 0) mUse[collide] = 1;
    wbCapN = 0;
    check(int'(reqReady), 1, {tag, " R7 ready when idle"});
    reqValid = 1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    if (collide >= 0) begin
      refValid = 1; refFrame = 3'(collide); refWrite = 0;
    end
    n = 0;
    while (!rspValid && n < 200) begin
      @(posedge clk);
      @(negedge clk);
      refValid = 0;
      n++;
    end
    check(n, steps, {tag, " R6 latency"});
    check(int'(n <= 3 * F), 1, {tag, " R6 bounded sweep"});
    check(int'(rspFrame), victim, {tag, " victim frame"});
    check(int'(rspDirty), vd, {tag, " victim dirty"});
    check(int'(reqReady), 0, {tag, " R7 busy"});
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check(int'(rspValid), 1, {tag, " R7 rsp held"});
      check(int'(rspFrame), victim, {tag, " R7 frame held"});
    end
    rspReady = 1;
    @(negedge clk);
    rspReady = 0;
    check(int'(rspValid), 0, {tag, " R7 rsp taken"});
    mUse[victim] = 0; mDirty[victim] = 0; mCnt[victim] = 0;
    if (!stall) begin
      check(wbCapN, expWbN, {tag, " R5 write-back count"});
      for (int k = 0; k < expWbN && k < wbCapN; k++)
        check(wbCap[k], expWb[k], {tag, " R5 write-back frame"});
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    doReset();
    check(int'(reqReady), 1, "R7 reset ready");
    check(int'(rspValid), 0, "R7 reset rsp");
    check(int'(wbValid), 0, "R11 reset wb");

    // R4: fresh pool, first frame picked at once
    doRequest(0, -1, 0, "R4 R2 clean first");
    // R10: reference hits frame 1 as it is inspected
    doRequest(0, 1, 2, "R10 collision");
    for (int i = 0; i < 7; i++) doRequest(0, -1, 0, "R10 R3 R9 follow-up");

    // R6: all used, clean: wraps and picks start frame
    doReset();
    for (int i = 0; i < F; i++) doRef(i, 0);
    doRequest(0, -1, 1, "R6 R1 R3 fifo");
    for (int i = 0; i < F; i++) doRef(i, 0);
    doRequest(0, -1, 0, "R6 R7 fifo next");

    // R5: all used and dirty, write-backs raised in order
    doReset();
    for (int i = 0; i < F; i++) doRef(i, 1);
    doRequest(0, -1, 0, "R5 R1 dirty sweep");
    // R8: completion makes frame 1 clean
    doDone(1);
    doRequest(0, -1, 0, "R8 done clears dirty");
    doRequest(0, -1, 0, "R5 dirty second visit");

    // R11: stalled write-back channel
    doReset();
    wbReady = 0;
    for (int i = 0; i < F; i++) doRef(i, 1);
    doRequest(1, -1, 0, "R11 stalled");
    check(int'(wbValid), 1, "R11 wb held");
    check(int'(wbFrame), 0, "R11 wb frame held");
    @(negedge clk);
    check(int'(wbValid), 1, "R11 wb still held");
    wbReady = 1;
    @(negedge clk);
    @(negedge clk);
    check(int'(wbValid), 0, "R11 wb accepted");
    doRequest(0, -1, 0, "R11 R5 skipped frame still dirty");

    // random phase
    doReset();
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 9);
      if (r <= 4) doRef($urandom_range(0, F - 1), ($urandom_range(0, 2) == 0));
      else if (r == 5) doDone($urandom_range(0, F - 1));
      else doRequest(0, -1, $urandom_range(0, 3), "R1 R2 R3 R4 R5 R8 R9 random");
    end

    finishRun();
  end

endmodule